// File: doc/BRIEF.md
# Serial Configuration EEPROM Read Controller

This block sits on the host register side of a network adapter and fetches 16-bit words from a small serial configuration EEPROM. The host writes a command byte to the command register. The two top bits of the byte are an opcode and the six low bits are a word address. For a read opcode the controller drives a three-wire serial frame to the EEPROM: chip select, serial clock and serial data out, with serial data returned on a fourth line. It assembles the reply and places it in a separate data register.

While a read runs, the top bit of the command register reads as 1. The host polls that bit and reads the data register once the bit is 0. The serial clock is the system clock divided by `CLK_DIV`. A read is sized to finish well inside a fixed time limit of 162 µs.

The write and erase opcodes are recognised and consumed but start no serial traffic. The enable and disable opcodes control a local write-grant flag, and the grant expires by itself after a set time.

Top module: `ee_cfg_reader`

## Requirements
- R1: After reset, and after a reset applied in the middle of a read, the busy bit, the grant bit, the command echo and the data register all read 0. Chip select, serial clock and serial data out are all 0.
- R2: A write to offset 10 with bits 7:6 of the byte equal to 2'b10 starts a read. The busy bit (bit 15 at offset 10) reads 1 from the next cycle on. Bits 7:0 at offset 10 echo the last accepted command byte. A write to any other offset starts nothing.
- R3: A read frame holds chip select high for exactly 26 serial clock rising edges. Serial data out carries, MSB first: a start bit 1, the opcode 1 then 0, the six address bits MSB first, and then 0 for the dummy bit and all 16 data bits. While chip select is low, serial clock and serial data out stay 0.
- R4: When busy returns to 0, offset 12 holds the 16 bits sampled on serial data in after data edges 11 to 26 of the frame, the first sampled bit as the MSB.
- R5: The busy bit stays 1 for no more than 162 µs worth of system clocks per read.
- R6: Chip select is low for at least `CLK_DIV` system clocks before every rising edge of chip select.
- R7: A command written while busy is 1 is ignored. It does not change the command echo, start a second frame, or change the grant flag.
- R8: Offset 12 keeps its value until the next read completes, including while a read is in progress.
- R9: Bytes with bits 7:6 equal to 2'b01 (write) or 2'b11 (erase) leave busy at 0, produce no frame and leave offset 12 unchanged.
- R10: Byte 0x30 sets the grant flag (bit 14 at offset 10) and byte 0x00 clears it. The flag clears itself after `LAPSE_US` µs (10 ms by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Register offset, used for both writes and reads |
| reg_wdata | input | 8 | Command byte written to offset 10 |
| reg_rdata | output | 16 | Combinational read data for the offset on reg_addr |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The assertions check several rules on every cycle. Serial clock and data stay quiet while chip select is low. Chip select has its guard gap before each frame. Busy never outlives the 162 µs budget. The command echo is frozen while busy, the data register changes only when a read ends, and write, erase and disable bytes have their immediate effects.

Other behaviour is only visible through the bench's scenarios against its EEPROM model. These cover the exact bit order of each frame, the 16-bit word assembled from the reply, commands dropped during a read, the data register read part-way through a read, and the self-expiry of the grant flag.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
    localparam int EE_AW      = 6;
    localparam int EE_DW      = 16;
    localparam int CMD_W      = 8;
    localparam int REG_AW     = 4;
    // start bit + 2 opcode bits + address + dummy + data
    localparam int FRAME_BITS = 1 + 2 + EE_AW + 1 + EE_DW;
    localparam int RX_FIRST   = FRAME_BITS - EE_DW;

    localparam logic [REG_AW-1:0] OFS_CMD  = 4'd10;
    localparam logic [REG_AW-1:0] OFS_DATA = 4'd12;
    localparam logic [1:0]        SER_OP_READ = 2'b10;

    typedef enum logic [2:0] {
        CK_READ, CK_WRITE, CK_ERASE, CK_GRANT, CK_REVOKE, CK_NONE
    } cmd_kind_t;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_LEAD, SQ_SHIFT
    } seq_state_t;

    typedef struct packed {
        logic [1:0]       op;
        logic [EE_AW-1:0] addr;
    } cmd_byte_t;

    function automatic cmd_kind_t classify(input logic [1:0] op, input logic [1:0] ext);
        cmd_kind_t k;
        case (op)
            2'b10:   k = CK_READ;
            2'b01:   k = CK_WRITE;
            2'b11:   k = CK_ERASE;
            default: begin
                if (ext == 2'b11)      k = CK_GRANT;
                else if (ext == 2'b00) k = CK_REVOKE;
                else                   k = CK_NONE;
            end
        endcase
        return k;
    endfunction
endpackage

// File: rtl/ee_bit_timer.sv
module ee_bit_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mid,
    output logic last
);
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign mid  = run && (cnt == CW'(HALF - 1));
    assign last = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ee_frame_seq.sv
module ee_frame_seq import ee_rd_pkg::*; #(
    parameter int DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [EE_AW-1:0] start_addr,
    input  logic             ee_do,
    output logic             ee_cs,
    output logic             ee_sk,
    output logic             ee_di,
    output logic             busy,
    output logic [EE_DW-1:0] word
);
    localparam int IW = $clog2(FRAME_BITS);

    seq_state_t            st;
    logic [IW-1:0]         idx;
    logic [FRAME_BITS-1:0] tx;
    logic [EE_DW-2:0]      rx;
    logic                  run, mid, last;

    assign run  = (st != SQ_IDLE);
    assign busy = run;

    ee_bit_timer #(.DIV(DIV)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .mid  (mid),
        .last (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            idx   <= '0;
            tx    <= '0;
            rx    <= '0;
            ee_cs <= 1'b0;
            ee_sk <= 1'b0;
            ee_di <= 1'b0;
            word  <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st <= SQ_LEAD;
                        tx <= {1'b1, SER_OP_READ, start_addr, 1'b0, {EE_DW{1'b0}}};
                    end
                end
                SQ_LEAD: begin
                    if (last) begin
                        st    <= SQ_SHIFT;
                        idx   <= '0;
                        ee_cs <= 1'b1;
                        ee_di <= tx[FRAME_BITS-1];
                    end
                end
                SQ_SHIFT: begin
                    if (mid) ee_sk <= 1'b1;
                    if (last) begin
                        ee_sk <= 1'b0;
                        if (idx == IW'(FRAME_BITS - 1)) begin
                            st    <= SQ_IDLE;
                            ee_cs <= 1'b0;
                            ee_di <= 1'b0;
                            word  <= {rx, ee_do};
                        end else begin
                            idx   <= idx + 1'b1;
                            tx    <= {tx[FRAME_BITS-2:0], 1'b0};
                            ee_di <= tx[FRAME_BITS-2];
                            if (idx >= IW'(RX_FIRST)) rx <= {rx[EE_DW-3:0], ee_do};
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ee_grant_timer.sv
module ee_grant_timer #(
    parameter int LAPSE = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic granted
);
    localparam int TW = $clog2(LAPSE + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            granted <= 1'b0;
            cnt     <= '0;
        end else if (clr) begin
            granted <= 1'b0;
        end else if (set) begin
            granted <= 1'b1;
            cnt     <= '0;
        end else if (granted) begin
            if (cnt == TW'(LAPSE - 1)) granted <= 1'b0;
            else                       cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ee_cfg_reader.sv
module ee_cfg_reader import ee_rd_pkg::*; #(
    parameter int CLK_DIV       = 100,
    parameter int CLK_MHZ       = 100,
    parameter int READ_LIMIT_US = 162,
    parameter int LAPSE_US      = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [EE_DW-1:0]  reg_rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int LAPSE_CYCLES = LAPSE_US * CLK_MHZ;
    localparam int PAD_W        = EE_DW - 2 - CMD_W;

    cmd_byte_t        cb;
    cmd_kind_t        kind;
    logic             cmd_hit, busy, granted;
    logic [CMD_W-1:0] cmd_q;
    logic [EE_DW-1:0] word;

    assign cb      = cmd_byte_t'(reg_wdata);
    assign kind    = classify(cb.op, cb.addr[EE_AW-1 -: 2]);
    assign cmd_hit = reg_wr && (reg_addr == OFS_CMD) && !busy;

    always_ff @(posedge clk) begin
        if (rst)          cmd_q <= '0;
        else if (cmd_hit) cmd_q <= reg_wdata;
    end

    ee_frame_seq #(.DIV(CLK_DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd_hit && (kind == CK_READ)),
        .start_addr (cb.addr),
        .ee_do      (ee_do),
        .ee_cs      (ee_cs),
        .ee_sk      (ee_sk),
        .ee_di      (ee_di),
        .busy       (busy),
        .word       (word)
    );

    ee_grant_timer #(.LAPSE(LAPSE_CYCLES)) u_grant (
        .clk     (clk),
        .rst     (rst),
        .set     (cmd_hit && (kind == CK_GRANT)),
        .clr     (cmd_hit && (kind == CK_REVOKE)),
        .granted (granted)
    );

    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = {busy, granted, {PAD_W{1'b0}}, cmd_q};
            OFS_DATA: reg_rdata = word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ee_cfg_reader_chk.sv
module ee_cfg_reader_chk import ee_rd_pkg::*; #(
    parameter int CLK_DIV       = 100,
    parameter int CLK_MHZ       = 100,
    parameter int READ_LIMIT_US = 162
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [CMD_W-1:0]  reg_wdata,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di,
    input logic              busy,
    input logic              granted,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [EE_DW-1:0]  word
);
    localparam int BUDGET = READ_LIMIT_US * CLK_MHZ;
    localparam int BW     = $clog2(BUDGET + 2);

    logic [BW-1:0] busy_run;
    logic [15:0]   low_run;
    logic          wr_free;

    assign wr_free = reg_wr && (reg_addr == OFS_CMD) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= '0;
            low_run  <= '0;
        end else begin
            if (!busy)                  busy_run <= '0;
            else if (busy_run != '1)    busy_run <= busy_run + 1'b1;
            if (ee_cs)                  low_run  <= '0;
            else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !granted && !ee_cs && !ee_sk && cmd_q == '0 && word == '0));

    a_r2_read_goes_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_free && reg_wdata[7:6] == 2'b10) |=> (busy && cmd_q == $past(reg_wdata)));

    a_r3_lines_quiet: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> (!ee_sk && !ee_di));

    a_r5_read_budget: assert property (@(posedge clk) disable iff (rst)
        busy_run <= BW'(BUDGET));

    a_r6_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_cs) |-> (low_run >= 16'(CLK_DIV)));

    a_r7_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> $stable(word));

    a_r9_no_frame_on_prog: assert property (@(posedge clk) disable iff (rst)
        (wr_free && reg_wdata[6]) |=> !busy);

    a_r10_revoke: assert property (@(posedge clk) disable iff (rst)
        (wr_free && reg_wdata[7:4] == 4'h0) |=> !granted);
endmodule

bind ee_cfg_reader ee_cfg_reader_chk #(
    .CLK_DIV       (CLK_DIV),
    .CLK_MHZ       (CLK_MHZ),
    .READ_LIMIT_US (READ_LIMIT_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .busy      (busy),
    .granted   (granted),
    .cmd_q     (cmd_q),
    .word      (word)
);

// File: tb/sim_ee_cfg_reader.sv
module sim_ee_cfg_reader;
    localparam int DIV      = 8;
    localparam int MHZ      = 100;
    localparam int LAPSE_US = 20;
    localparam int LAPSE    = LAPSE_US * MHZ;
    localparam int BUDGET   = 162 * MHZ;
    localparam logic [3:0] A_CMD  = 4'd10;
    localparam logic [3:0] A_DATA = 4'd12;
    localparam int NV = 8;
    localparam logic [5:0] VEC_ADDR [NV] = '{6'h00, 6'h3F, 6'h15, 6'h2A, 6'h01, 6'h20, 6'h1F, 6'h3E};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [15:0] reg_rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    int         m_k = 0;
    int         m_frames = 0;
    logic [8:0] m_cmd = '0;
    logic       m_di_bad = 1'b0;
    logic [15:0] m_w;
    logic       cs_prev = 1'b0;
    logic       sk_prev = 1'b0;
    int         gap = 0;
    int         min_gap = 1000000;

    always #5 clk = ~clk;

    ee_cfg_reader #(
        .CLK_DIV(DIV), .CLK_MHZ(MHZ), .READ_LIMIT_US(162), .LAPSE_US(LAPSE_US)
    ) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] model_word(input logic [5:0] a);
        return {a, ~a[3:0], a} ^ 16'hA55A;
    endfunction

    // EEPROM model and chip-select gap monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (ee_cs === 1'b1 && !cs_prev) begin
            if (gap < min_gap) min_gap = gap;
            gap = 0;
            m_k = 0;
            m_cmd = '0;
            m_di_bad = 1'b0;
            m_frames++;
        end
        if (ee_cs !== 1'b1) gap++;
        if (ee_cs === 1'b1 && ee_sk === 1'b1 && !sk_prev) begin
            m_k++;
            if (m_k <= 9) m_cmd = {m_cmd[7:0], ee_di};
            else if (ee_di !== 1'b0) m_di_bad = 1'b1;
            if (m_k == 10) ee_do = 1'b0;
            else if (m_k >= 11 && m_k <= 26) begin
                m_w = model_word(m_cmd[5:0]);
                ee_do = m_w[26 - m_k];
            end
        end
        cs_prev = (ee_cs === 1'b1);
        sk_prev = (ee_sk === 1'b1);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] val);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        logic [15:0] v;
        cyc = 0;
        rd(A_CMD, v);
        while (v[15] && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            rd(A_CMD, v);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] held;
        int cyc;
        int f0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CMD, v);  chk("R1 cmd reg", v, 16'h0000);
        rd(A_DATA, v); chk("R1 data reg", v, 16'h0000);
        chk("R1 lines", {ee_cs, ee_sk, ee_di}, 3'b000);

        // R2/R3/R4/R5: table of reads
        for (int i = 0; i < NV; i++) begin
            f0 = m_frames;
            wr(A_CMD, {2'b10, VEC_ADDR[i]});
            rd(A_CMD, v);  chk("R2 busy set", v[15], 1'b1);
            wait_idle(cyc);
            chk("R5 within budget", (cyc <= BUDGET), 1'b1);
            chk("R3 command bits", m_cmd, {3'b110, VEC_ADDR[i]});
            chk("R3 edge count", m_k, 26);
            chk("R3 dummy/data di low", m_di_bad, 1'b0);
            chk("R3 one frame", m_frames, f0 + 1);
            rd(A_DATA, v); chk("R4 data word", v, model_word(VEC_ADDR[i]));
            rd(A_CMD, v);  chk("R2 echo", v[7:0], {2'b10, VEC_ADDR[i]});
        end

        // R7: commands while busy are dropped
        f0 = m_frames;
        wr(A_CMD, 8'h91);
        idle(2);
        wr(A_CMD, 8'hA2);
        wr(A_CMD, 8'h30);
        wait_idle(cyc);
        idle(3 * DIV);
        chk("R7 single frame", m_frames, f0 + 1);
        rd(A_DATA, v); chk("R7 data of first", v, model_word(6'h11));
        rd(A_CMD, v);  chk("R7 echo kept", v[7:0], 8'h91);
        chk("R7 grant untouched", v[14], 1'b0);

        // R8: data holds during next read
        held = model_word(6'h11);
        wr(A_CMD, 8'hAC);
        idle(100);
        rd(A_CMD, v);  chk("R8 mid read busy", v[15], 1'b1);
        rd(A_DATA, v); chk("R8 old data held", v, held);
        wait_idle(cyc);
        rd(A_DATA, v); chk("R8 new data", v, model_word(6'h2C));

        // R9: write and erase opcodes start nothing
        held = model_word(6'h2C);
        f0 = m_frames;
        wr(A_CMD, 8'h45);
        rd(A_CMD, v);  chk("R9 write no busy", v[15], 1'b0);
        wr(A_CMD, 8'hC7);
        rd(A_CMD, v);  chk("R9 erase no busy", v[15], 1'b0);
        idle(300);
        chk("R9 no frame", m_frames, f0);
        rd(A_DATA, v); chk("R9 data kept", v, held);
        rd(A_CMD, v);  chk("R9 echo", v[7:0], 8'hC7);

        // R2: read opcode at the data offset is not a command
        wr(A_DATA, 8'h85);
        rd(A_CMD, v);  chk("R2 other offset no busy", v[15], 1'b0);
        idle(50);
        chk("R2 other offset no frame", m_frames, f0);

        // R10: grant, revoke and self-expiry
        wr(A_CMD, 8'h30);
        rd(A_CMD, v);  chk("R10 grant set", v[14], 1'b1);
        wr(A_CMD, 8'h00);
        rd(A_CMD, v);  chk("R10 revoke", v[14], 1'b0);
        wr(A_CMD, 8'h30);
        idle(LAPSE - 10);
        rd(A_CMD, v);  chk("R10 still granted", v[14], 1'b1);
        idle(20);
        rd(A_CMD, v);  chk("R10 lapsed", v[14], 1'b0);

        // R6: chip-select guard time seen by the monitor
        chk("R6 cs gap", (min_gap >= DIV), 1'b1);

        // R1: reset in the middle of a read
        wr(A_CMD, 8'h8A);
        idle(60);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(A_CMD, v);  chk("R1 mid-read reset cmd", v, 16'h0000);
        rd(A_DATA, v); chk("R1 mid-read reset data", v, 16'h0000);
        chk("R1 mid-read reset lines", {ee_cs, ee_sk, ee_di}, 3'b000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule